// File: doc/BRIEF.md
# Condition Code and Next-PC Unit

This block belongs to the control path of a small 16-bit processor. It holds the three-bit sign-class register (negative, zero, positive) and the program counter. On every step strobe it does two things. It decides whether the current instruction writes a general register, and if so it reloads the sign-class register from the value on the internal bus. It also picks the next program counter from one of three sources: the incremented counter, the address adder, and the bus.

The address adder adds a sign-extended 9-bit displacement to the incremented counter for a taken conditional branch. For a register jump it passes the jump-register operand with a zero displacement. The bus source serves service-call instructions, whose target is looked up elsewhere and presented on the bus.

The taken indicator is combinational. It is computed from the instruction word and the sign class held before the step. Everything that holds state changes only on a clock edge where the step strobe is high.

Top module: `cond_pc_unit`

## Requirements
- R1: A synchronous active-high reset sets the counter to 16'h3000 and the sign class to zero (flags = 3'b010).
- R2: After reset, exactly one of the three flag bits is set at every clock edge.
- R3: On a step whose opcode (instruction bits 15:12) is 1, 5, 9, 2, 6, 10 or 14, the flags load from the bus value. A negative value gives 3'b100, zero gives 3'b010, and a positive value gives 3'b001. Flag bit 2 is N, bit 1 is Z and bit 0 is P.
- R4: On a step with any other opcode, the flags keep their value.
- R5: With the step strobe low, the counter and the flags hold, whatever the other inputs are.
- R6: A step with an opcode other than 0, 12 or 15, or with opcode 0 not taken, sets the counter to the old counter plus one, modulo 2^16.
- R7: With opcode 0, the condition mask is bits 11:9 (bit 11 tests N, bit 10 tests Z, bit 9 tests P). br_taken is high exactly when some mask bit and its matching flag are both set. br_taken is low for every other opcode.
- R8: A step on a taken branch sets the counter to the old counter plus one plus the sign-extended bits 8:0, modulo 2^16.
- R9: A branch with mask 3'b000 is never taken.
- R10: A step with opcode 12 loads the counter with jreg_val.
- R11: A step with opcode 15 loads the counter with bus_val.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Commits the flag update and the counter load on this edge |
| instr | input | 16 | Current instruction word |
| bus_val | input | 16 | Value on the internal bus |
| jreg_val | input | 16 | Register operand for a register jump |
| pc | output | 16 | Program counter |
| flags | output | 3 | Sign class: bit 2 N, bit 1 Z, bit 0 P |
| br_taken | output | 1 | Current branch instruction is taken |

## Verification
A wrong sign class shows on the flags port at the edge after the faulty step. It shows again in the next cycle through br_taken, because every one of the eight masks is tried against each of the three sign classes. A wrong counter source or a wrong adder input shows on pc one edge after the step. The bench sweeps all sixteen opcodes against negative, zero and positive bus values, and tries displacements at both ends of the 9-bit range. Cycles without a step check that the counter and the flags hold.

// File: rtl/cc_pc_pkg.sv
package cc_pc_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 4;
    localparam int MASK_W = 3;
    localparam int DISP_W = 9;

    typedef enum logic [OPC_W-1:0] {
        OP_BR   = 4'h0,
        OP_ADD  = 4'h1,
        OP_LD   = 4'h2,
        OP_ST   = 4'h3,
        OP_JSR  = 4'h4,
        OP_AND  = 4'h5,
        OP_LDR  = 4'h6,
        OP_STR  = 4'h7,
        OP_RTI  = 4'h8,
        OP_NOT  = 4'h9,
        OP_LDI  = 4'hA,
        OP_STI  = 4'hB,
        OP_JMP  = 4'hC,
        OP_RSV  = 4'hD,
        OP_LEA  = 4'hE,
        OP_TRAP = 4'hF
    } opcode_e;

    // Bit order matches the branch mask: neg tested by the top mask bit.
    typedef struct packed {
        logic neg;
        logic zero;
        logic pos;
    } cond_t;

    typedef enum logic [1:0] {
        SRC_INC   = 2'd0,
        SRC_ADDER = 2'd1,
        SRC_BUS   = 2'd2
    } pc_src_e;

    localparam cond_t COND_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};

    // Instructions that write a general register and so refresh the flags.
    function automatic logic writes_reg(opcode_e op);
        case (op)
            OP_ADD, OP_AND, OP_NOT, OP_LD, OP_LDR, OP_LDI, OP_LEA: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Instructions that do not simply advance the counter.
    function automatic logic redirects(opcode_e op);
        return (op == OP_BR) || (op == OP_JMP) || (op == OP_TRAP);
    endfunction

endpackage

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
    import cc_pc_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  opcode_e           op,
    input  logic [DATA_W-1:0] bus_val,
    output cond_t             flags
);

    localparam int SIGN_BIT = DATA_W - 1;

    logic  load_en;
    cond_t sampled;

    assign load_en = step && writes_reg(op);

    always_comb begin
        sampled = '0;
        if (bus_val[SIGN_BIT])
            sampled.neg = 1'b1;
        else if (bus_val == '0)
            sampled.zero = 1'b1;
        else
            sampled.pos = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags <= COND_RESET;
        else if (load_en)
            flags <= sampled;
    end

    // R2
    flag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(flags) == 1);

    // R3
    flag_neg_load_chk: assert property (@(posedge clk) disable iff (rst)
        (step && writes_reg(op) && bus_val[SIGN_BIT]) |=> flags.neg);

    // R3
    flag_zero_load_chk: assert property (@(posedge clk) disable iff (rst)
        (step && writes_reg(op) && bus_val == '0) |=> flags.zero);

    // R4
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !writes_reg(op)) |=> $stable(flags));

    // R5
    flag_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(flags));

endmodule

// File: rtl/cc_branch_eval.sv
module cc_branch_eval
    import cc_pc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  opcode_e           op,
    input  logic [MASK_W-1:0] mask,
    input  cond_t             flags,
    output logic              taken
);

    logic [MASK_W-1:0] hits;

    assign hits  = mask & flags;
    assign taken = (op == OP_BR) && (hits != '0);

    // R9
    empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !taken);

    // R7
    taken_only_br_chk: assert property (@(posedge clk) disable iff (rst)
        taken |-> (op == OP_BR));

endmodule

// File: rtl/cc_pc_select.sv
module cc_pc_select
    import cc_pc_pkg::*;
#(
    parameter int              DATA_W   = WORD_W,
    parameter int              OFF_W    = DISP_W,
    parameter logic [DATA_W-1:0] RESET_PC = 16'h3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  opcode_e           op,
    input  logic              taken,
    input  logic [OFF_W-1:0]  disp,
    input  logic [DATA_W-1:0] bus_val,
    input  logic [DATA_W-1:0] jreg_val,
    output logic [DATA_W-1:0] pc
);

    localparam int EXT_W = DATA_W - OFF_W;

    pc_src_e           src;
    logic [DATA_W-1:0] pc_inc;
    logic [DATA_W-1:0] adder_base;
    logic [DATA_W-1:0] adder_off;
    logic [DATA_W-1:0] adder_out;
    logic [DATA_W-1:0] pc_next;

    assign pc_inc = pc + DATA_W'(1);

    always_comb begin
        src        = SRC_INC;
        adder_base = pc_inc;
        adder_off  = {{EXT_W{disp[OFF_W-1]}}, disp};
        case (op)
            OP_BR:   if (taken) src = SRC_ADDER;
            OP_JMP: begin
                src        = SRC_ADDER;
                adder_base = jreg_val;
                adder_off  = '0;
            end
            OP_TRAP: src = SRC_BUS;
            default: src = SRC_INC;
        endcase
    end

    assign adder_out = adder_base + adder_off;

    always_comb begin
        case (src)
            SRC_ADDER: pc_next = adder_out;
            SRC_BUS:   pc_next = bus_val;
            default:   pc_next = pc_inc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc <= RESET_PC;
        else if (step)
            pc <= pc_next;
    end

    // R5
    pc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc));

    // R6
    pc_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (step && (!redirects(op) || (op == OP_BR && !taken)))
        |=> pc == $past(pc) + DATA_W'(1));

    // R8
    pc_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (step && taken)
        |=> pc == $past(pc) + DATA_W'(1) + {{EXT_W{$past(disp[OFF_W-1])}}, $past(disp)});

    // R10
    pc_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (step && op == OP_JMP) |=> pc == $past(jreg_val));

    // R11
    pc_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && op == OP_TRAP) |=> pc == $past(bus_val));

endmodule

// File: rtl/cond_pc_unit.sv
module cond_pc_unit
    import cc_pc_pkg::*;
#(
    parameter int                DATA_W   = WORD_W,
    parameter logic [DATA_W-1:0] RESET_PC = 16'h3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W-1:0] bus_val,
    input  logic [DATA_W-1:0] jreg_val,
    output logic [DATA_W-1:0] pc,
    output logic [2:0]        flags,
    output logic              br_taken
);

    localparam int OPC_LSB  = DATA_W - OPC_W;
    localparam int MASK_LSB = OPC_LSB - MASK_W;

    opcode_e           op;
    logic [MASK_W-1:0] mask;
    logic [DISP_W-1:0] disp;
    cond_t             cond_q;
    logic              taken;

    assign op   = opcode_e'(instr[DATA_W-1:OPC_LSB]);
    assign mask = instr[OPC_LSB-1:MASK_LSB];
    assign disp = instr[DISP_W-1:0];

    cc_flag_reg #(.DATA_W(DATA_W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .op      (op),
        .bus_val (bus_val),
        .flags   (cond_q)
    );

    cc_branch_eval u_branch (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .mask  (mask),
        .flags (cond_q),
        .taken (taken)
    );

    cc_pc_select #(
        .DATA_W   (DATA_W),
        .OFF_W    (DISP_W),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .op       (op),
        .taken    (taken),
        .disp     (disp),
        .bus_val  (bus_val),
        .jreg_val (jreg_val),
        .pc       (pc)
    );

    assign flags    = cond_q;
    assign br_taken = taken;

endmodule

// File: tb/tb_cond_pc_unit.sv
module tb_cond_pc_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        step;
    logic [15:0] instr;
    logic [15:0] bus_val;
    logic [15:0] jreg_val;
    logic [15:0] pc;
    logic [2:0]  flags;
    logic        br_taken;

    int n_chk  = 0;
    int n_fail = 0;

    logic [15:0] m_pc;
    logic [2:0]  m_flags;

    always #5 clk = ~clk;

    cond_pc_unit dut (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .instr    (instr),
        .bus_val  (bus_val),
        .jreg_val (jreg_val),
        .pc       (pc),
        .flags    (flags),
        .br_taken (br_taken)
    );

    function automatic logic [2:0] cond_of(logic [15:0] v);
        if (v[15])       return 3'b100;
        else if (v == 0) return 3'b010;
        else             return 3'b001;
    endfunction

    function automatic logic loads_flags(logic [3:0] op);
        return op == 4'h1 || op == 4'h5 || op == 4'h9 || op == 4'h2 ||
               op == 4'h6 || op == 4'hA || op == 4'hE;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_step(logic [15:0] ins, logic [15:0] bv, logic [15:0] jv);
        logic [3:0]  op;
        logic [2:0]  m;
        logic        exp_t;
        logic [15:0] exp_pc;
        logic [2:0]  exp_f;
        string       pc_tag;
        op = ins[15:12];
        m  = ins[11:9];
        @(negedge clk);
        instr = ins; bus_val = bv; jreg_val = jv; step = 1'b1;
        #1;
        exp_t = (op == 4'h0) && ((m & m_flags) != 3'b000);
        chk((op == 4'h0 && m == 3'b000) ? "R9" : "R7", 16'(br_taken), 16'(exp_t));
        if (op == 4'h0 && exp_t) begin
            exp_pc = m_pc + 16'd1 + {{7{ins[8]}}, ins[8:0]};
            pc_tag = "R8";
        end else if (op == 4'hC) begin
            exp_pc = jv; pc_tag = "R10";
        end else if (op == 4'hF) begin
            exp_pc = bv; pc_tag = "R11";
        end else begin
            exp_pc = m_pc + 16'd1; pc_tag = "R6";
        end
        exp_f = loads_flags(op) ? cond_of(bv) : m_flags;
        @(posedge clk);
        #1;
        step = 1'b0;
        chk(pc_tag, pc, exp_pc);
        chk(loads_flags(op) ? "R3" : "R4", 16'(flags), 16'(exp_f));
        chk("R2", 16'($countones(flags)), 16'd1);
        m_pc = exp_pc;
        m_flags = exp_f;
    endtask

    task automatic idle(logic [15:0] ins, logic [15:0] bv);
        @(negedge clk);
        instr = ins; bus_val = bv; jreg_val = ~bv; step = 1'b0;
        @(posedge clk);
        #1;
        chk("R5", pc, m_pc);
        chk("R5", 16'(flags), 16'(m_flags));
    endtask

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] bus_set[5];
        logic [15:0] flag_src[3];
        logic [8:0]  disp_set[3];
        bus_set  = '{16'h8000, 16'hFFFF, 16'h0000, 16'h0001, 16'h7FFF};
        flag_src = '{16'h8001, 16'h0000, 16'h0042};
        disp_set = '{9'h100, 9'h0FF, 9'h001};
        rst = 1'b1; step = 1'b0; instr = '0; bus_val = '0; jreg_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", pc, 16'h3000);
        chk("R1", 16'(flags), 16'(3'b010));
        m_pc = 16'h3000;
        m_flags = 3'b010;

        // Worked loop example: back branch and forward branch on zero
        do_step(16'hF000, 16'h3009, 16'h0);
        do_step(16'h0FFA, 16'h1234, 16'h0);
        chk("R8", pc, 16'h3004);
        do_step(16'h0405, 16'h0, 16'h0);
        chk("R8", pc, 16'h300A);

        // Opcode sweep against negative, zero and positive bus values
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 5; k++) begin
                logic [11:0] low;
                low = 12'((op * 37 + k * 113 + 5) & 12'hFFF);
                do_step({4'(op), low}, bus_set[k], 16'(16'h4100 + op * 16 + k));
            end
        end

        // Every mask against every sign class, displacements at range ends
        for (int f = 0; f < 3; f++) begin
            for (int m = 0; m < 8; m++) begin
                do_step(16'h1000, flag_src[f], 16'h0);
                do_step({4'h0, 3'(m), disp_set[m % 3]}, 16'hBEEF, 16'h0);
            end
        end

        // Counter wrap and jump to arbitrary address
        do_step(16'hF000, 16'hFFFF, 16'h0);
        do_step(16'h3000, 16'h0005, 16'h0);
        chk("R6", pc, 16'h0000);
        do_step(16'hC1C0, 16'h0, 16'hA5A5);
        chk("R10", pc, 16'hA5A5);

        // No step: nothing moves
        idle(16'h1000, 16'h8000);
        idle(16'hF000, 16'h1234);
        idle(16'hC000, 16'h0000);
        idle(16'h0E01, 16'h0001);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule